// File: doc/BRIEF.md
# Ethernet MAC Statistics Counter Bank

This block holds the traffic counters for one direction of a 10G Ethernet MAC. Two instances are needed for a full MAC, one for the transmit side and one for the receive side. They differ only in their base word address. At the close of each frame, the datapath raises a single-cycle strobe. The strobe carries an error flag, a CRC-error flag, the payload byte count (data plus padding, control frames included) and the number of VLAN tag bytes seen in the frame.

Four wide counters are built from flip-flops: completed-good frames, errored frames, CRC-errored frames, and payload octets of good frames. Software reads each counter through a 32-bit register port as two words. Reading the low word freezes the upper bits, so the word pair that comes back is one coherent value. A write of 1 to bit 0 of the clear register empties the whole bank.

Top module: `mac_stat_bank`

## Requirements
- R1: After reset every counter, every high-word snapshot and the read data output are zero.
- R2: A strobe with both error flags low adds 1 to the good-frame counter.
- R3: A strobe with the error flag or the CRC-error flag set adds 1 to the errored-frame counter. No strobe changes both the good-frame and the errored-frame counter.
- R4: A strobe with the CRC-error flag set adds 1 to the CRC-error counter, and it also counts as an errored frame.
- R5: For a good frame, the octet counter adds the payload byte count. Errored frames add nothing.
- R6: The tag byte count of a good frame is added to the octet counter only while `tag_cnt_en_i` is 1. While it is 0 the tag bytes are ignored.
- R7: Word map relative to `BASE_ADDR`: +0 clear register; +2/+3 good frames; +4/+5 errored frames; +6/+7 CRC errors; +8/+9 octets; the low word comes first. Any other address, +1 included, reads as zero.
- R8: A write with bit 0 set at +0 zeroes all counters at the second rising edge after the write is sampled. The clear wins over a frame strobe in that cycle or in the cycle of the write. A write with bit 0 clear changes nothing. The clear register always reads as zero.
- R9: Reading a low word stores bits 35:32 of that counter. A later read of its high word returns the stored bits in [3:0] and zeros above, even if the counter has moved since.
- R10: Counters are 36 bits wide and wrap modulo 2^36 without saturating.
- R11: Read data appears on `reg_rdata_o` one rising edge after `reg_rd_i` is sampled, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eof_valid_i | input | 1 | End-of-frame status strobe |
| eof_err_i | input | 1 | Frame finished with an error of any kind |
| eof_crc_err_i | input | 1 | Frame finished with a CRC error |
| eof_len_i | input | LEN_W | Payload bytes (data plus padding) |
| eof_tag_len_i | input | TAG_W | VLAN tag bytes in the frame |
| tag_cnt_en_i | input | 1 | Include tag bytes in the octet count |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |

## Verification
Directed frames come first. They separate good, plain-error and CRC-error outcomes, and they separate tag bytes with counting enabled from tag bytes with counting disabled. Random frames then mix all four flag combinations with payload lengths from zero up to the full 32-bit range, so every counter is checked against a model that carries into the upper word. Four directed cases follow. A clear is written with a frame arriving alongside it and another right after it. A clear write with bit 0 low must have no effect. The counter moves between the low and high reads, to show that the snapshot is what comes back. Finally, payloads push the octet counter just past 2^36 to check the wrap.

// File: rtl/mac_stat_pkg.sv
package mac_stat_pkg;
  localparam int unsigned NUM_CNT      = 4;
  localparam int unsigned IDX_GOOD     = 0;
  localparam int unsigned IDX_ERR      = 1;
  localparam int unsigned IDX_CRC      = 2;
  localparam int unsigned IDX_OCT      = 3;
  localparam int unsigned OFF_CLR      = 0;
  localparam int unsigned OFF_CNT_BASE = 2;
  localparam int unsigned MAP_SPAN     = OFF_CNT_BASE + 2 * NUM_CNT;
endpackage

// File: rtl/mac_stat_decode.sv
module mac_stat_decode
  import mac_stat_pkg::*;
#(
  parameter int unsigned CNT_W = 36,
  parameter int unsigned LEN_W = 16,
  parameter int unsigned TAG_W = 4
) (
  input  logic                              valid_i,
  input  logic                              err_i,
  input  logic                              crc_i,
  input  logic [LEN_W-1:0]                  len_i,
  input  logic [TAG_W-1:0]                  tag_len_i,
  input  logic                              tag_en_i,
  output logic [NUM_CNT-1:0]                inc_o,
  output logic [NUM_CNT-1:0][CNT_W-1:0]     add_o
);
  logic bad;

  always_comb begin
    bad = err_i | crc_i;
    inc_o = '0;
    inc_o[IDX_GOOD] = valid_i & ~bad;
    inc_o[IDX_ERR]  = valid_i & bad;
    inc_o[IDX_CRC]  = valid_i & crc_i;
    inc_o[IDX_OCT]  = valid_i & ~bad;
    add_o = '0;
    add_o[IDX_GOOD] = CNT_W'(1);
    add_o[IDX_ERR]  = CNT_W'(1);
    add_o[IDX_CRC]  = CNT_W'(1);
    add_o[IDX_OCT]  = CNT_W'(len_i) + (tag_en_i ? CNT_W'(tag_len_i) : '0);
  end
endmodule

// File: rtl/mac_stat_ctr.sv
module mac_stat_ctr #(
  parameter int unsigned W = 36
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] add_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + add_i;  // modulo 2^W
  end

  assign cnt_o = cnt_q;

  a_r8_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
  a_r1_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(cnt_o));
endmodule

// File: rtl/mac_stat_regif.sv
module mac_stat_regif
  import mac_stat_pkg::*;
#(
  parameter int unsigned CNT_W     = 36,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned BASE_ADDR = 32'h140
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          wr_i,
  input  logic                          rd_i,
  input  logic [31:0]                   wdata_i,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_i,
  output logic                          clr_o,
  output logic [31:0]                   rdata_o
);
  localparam int unsigned HI_W = CNT_W - 32;
  localparam logic [ADDR_W-1:0] BASE_L = ADDR_W'(BASE_ADDR);

  logic [ADDR_W-1:0]           off;
  logic                        in_rng;
  logic                        clr_hit;
  logic [NUM_CNT-1:0]          lo_hit, hi_hit;
  logic [31:0]                 rdata_d, rdata_q;
  logic                        clr_q;
  logic [NUM_CNT-1:0][HI_W-1:0] snap_q;

  always_comb begin
    off     = addr_i - BASE_L;
    in_rng  = (addr_i >= BASE_L) && (off < ADDR_W'(MAP_SPAN));
    clr_hit = wr_i && in_rng && (off == ADDR_W'(OFF_CLR)) && wdata_i[0];
    lo_hit  = '0;
    hi_hit  = '0;
    rdata_d = '0;
    for (int k = 0; k < NUM_CNT; k++) begin
      lo_hit[k] = rd_i && in_rng && (off == ADDR_W'(OFF_CNT_BASE + 2 * k));
      hi_hit[k] = rd_i && in_rng && (off == ADDR_W'(OFF_CNT_BASE + 2 * k + 1));
      if (lo_hit[k]) rdata_d = cnt_i[k][31:0];
      if (hi_hit[k]) rdata_d = 32'(snap_q[k]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      clr_q <= clr_hit;  // self-clearing pulse
      if (rd_i) rdata_q <= rdata_d;
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_snap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        snap_q[g] <= '0;
      else if (clr_q)     snap_q[g] <= '0;
      else if (lo_hit[g]) snap_q[g] <= cnt_i[g][CNT_W-1:32];
    end

    a_r9_pair_coherent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hi_hit[g] && $past(lo_hit[g]) && !clr_q && !$past(clr_q))
        |=> rdata_o == 32'($past(cnt_i[g][CNT_W-1:32], 2)));
  end

  assign clr_o   = clr_q;
  assign rdata_o = rdata_q;

  a_r7_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !in_rng) |=> rdata_o == '0);
  a_r8_clr_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && in_rng && off == ADDR_W'(OFF_CLR)) |=> rdata_o == '0);
  a_r11_hold_rdata: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/mac_stat_bank.sv
module mac_stat_bank
  import mac_stat_pkg::*;
#(
  parameter int unsigned CNT_W     = 36,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned TAG_W     = 4,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned BASE_ADDR = 32'h140
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eof_valid_i,
  input  logic              eof_err_i,
  input  logic              eof_crc_err_i,
  input  logic [LEN_W-1:0]  eof_len_i,
  input  logic [TAG_W-1:0]  eof_tag_len_i,
  input  logic              tag_cnt_en_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o
);
  logic [NUM_CNT-1:0]            inc;
  logic [NUM_CNT-1:0][CNT_W-1:0] add;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
  logic                          clr;

  mac_stat_decode #(.CNT_W(CNT_W), .LEN_W(LEN_W), .TAG_W(TAG_W)) u_dec (
    .valid_i   (eof_valid_i),
    .err_i     (eof_err_i),
    .crc_i     (eof_crc_err_i),
    .len_i     (eof_len_i),
    .tag_len_i (eof_tag_len_i),
    .tag_en_i  (tag_cnt_en_i),
    .inc_o     (inc),
    .add_o     (add)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_ctr
    mac_stat_ctr #(.W(CNT_W)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .inc_i  (inc[g]),
      .add_i  (add[g]),
      .cnt_o  (cnt[g])
    );
  end

  mac_stat_regif #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regif (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (reg_addr_i),
    .wr_i    (reg_wr_i),
    .rd_i    (reg_rd_i),
    .wdata_i (reg_wdata_i),
    .cnt_i   (cnt),
    .clr_o   (clr),
    .rdata_o (reg_rdata_o)
  );

  a_r3_one_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inc[IDX_GOOD] && inc[IDX_ERR]));
  a_r4_crc_is_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc[IDX_CRC] |-> inc[IDX_ERR]);
  a_r2_good_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof_valid_i && !eof_err_i && !eof_crc_err_i && !clr)
      |=> cnt[IDX_GOOD] == $past(cnt[IDX_GOOD]) + CNT_W'(1));
  a_r5_err_no_octets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof_valid_i && (eof_err_i || eof_crc_err_i) && !clr)
      |=> cnt[IDX_OCT] == $past(cnt[IDX_OCT]));
endmodule

// File: tb/mac_stat_bank_test.sv
module mac_stat_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 32;
  localparam int TAG_W = 4;
  localparam int ADDR_W = 10;
  localparam logic [9:0] BASE = 10'h140;
  localparam longint unsigned MASK = (64'd1 << 36) - 1;

  logic clk = 0, rst_ni = 0;
  logic eof_valid_i = 0, eof_err_i = 0, eof_crc_err_i = 0, tag_cnt_en_i = 0;
  logic [LEN_W-1:0] eof_len_i = '0;
  logic [TAG_W-1:0] eof_tag_len_i = '0;
  logic [ADDR_W-1:0] reg_addr_i = '0;
  logic reg_wr_i = 0, reg_rd_i = 0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;

  int vecs = 0, fails = 0;
  bit done = 0;
  longint unsigned mdl[4];

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_stat_bank #(.LEN_W(LEN_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .BASE_ADDR(32'h140)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .eof_valid_i(eof_valid_i), .eof_err_i(eof_err_i),
    .eof_crc_err_i(eof_crc_err_i), .eof_len_i(eof_len_i), .eof_tag_len_i(eof_tag_len_i),
    .tag_cnt_en_i(tag_cnt_en_i), .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i),
    .reg_rd_i(reg_rd_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o));

  task automatic chk(input bit ok, input string req, input longint unsigned act, input longint unsigned exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic longint unsigned oct_add(input logic [LEN_W-1:0] len, input logic [TAG_W-1:0] tag, input bit ten);
    return longint'(len) + (ten ? longint'(tag) : 0);
  endfunction

  task automatic model_frame(input bit err, input bit crc, input logic [LEN_W-1:0] len,
                             input logic [TAG_W-1:0] tag, input bit ten);
    if (!err && !crc) begin
      mdl[0] = (mdl[0] + 1) & MASK;
      mdl[3] = (mdl[3] + oct_add(len, tag, ten)) & MASK;
    end else begin
      mdl[1] = (mdl[1] + 1) & MASK;
      if (crc) mdl[2] = (mdl[2] + 1) & MASK;
    end
  endtask

  task automatic drive_frame(input bit err, input bit crc, input logic [LEN_W-1:0] len,
                             input logic [TAG_W-1:0] tag, input bit ten);
    eof_valid_i = 1; eof_err_i = err; eof_crc_err_i = crc;
    eof_len_i = len; eof_tag_len_i = tag; tag_cnt_en_i = ten;
  endtask

  task automatic send_frame(input bit err, input bit crc, input logic [LEN_W-1:0] len,
                            input logic [TAG_W-1:0] tag, input bit ten);
    @(negedge clk);
    drive_frame(err, crc, len, tag, ten);
    model_frame(err, crc, len, tag, ten);
    @(negedge clk);
    eof_valid_i = 0;
  endtask

  task automatic rd_word(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_rd_i = 1;
    @(negedge clk);
    reg_rd_i = 0;
    d = reg_rdata_o;
  endtask

  task automatic wr_word(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1;
    @(negedge clk);
    reg_wr_i = 0;
    @(negedge clk);
  endtask

  task automatic check_cnt(input int idx, input string req);
    logic [31:0] lo, hi;
    longint unsigned exp, act;
    exp = mdl[idx];
    rd_word(BASE + ADDR_W'(2 + 2 * idx), lo);
    rd_word(BASE + ADDR_W'(3 + 2 * idx), hi);
    act = {hi, lo};
    chk(act == exp, req, act, exp);
  endtask

  task automatic check_all(input string req);
    check_cnt(0, {req, " good"});
    check_cnt(1, {req, " err"});
    check_cnt(2, {req, " crc"});
    check_cnt(3, {req, " oct"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) mdl[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1;

    // R1 reset state, R11 output idle
    chk(reg_rdata_o == 0, "R1 rdata after reset", reg_rdata_o, 0);
    check_all("R1");
    // R7 / R8 register map corners
    rd_word(BASE, d);              chk(d == 0, "R8 clear reg reads zero", d, 0);
    rd_word(BASE + 10'd1, d);      chk(d == 0, "R7 gap reads zero", d, 0);
    rd_word(BASE + 10'd10, d);     chk(d == 0, "R7 past end reads zero", d, 0);

    // R2 R5 R6 directed
    send_frame(0, 0, 64, 4, 0);
    check_cnt(0, "R2 good count");
    check_cnt(3, "R6 tag ignored when disabled");
    send_frame(0, 0, 100, 8, 1);
    check_cnt(3, "R6 tag added when enabled");
    send_frame(1, 0, 500, 4, 1);
    check_cnt(1, "R3 err count");
    check_cnt(0, "R3 good untouched by err");
    check_cnt(3, "R5 err adds no octets");
    send_frame(0, 1, 300, 0, 0);
    check_cnt(2, "R4 crc count");
    check_cnt(1, "R4 crc also err");

    // R11 hold: read value stays after rd drops
    rd_word(BASE + 10'd2, d);
    repeat (3) @(negedge clk);
    chk(reg_rdata_o == d, "R11 rdata holds", reg_rdata_o, d);

    // random traffic
    for (int n = 0; n < 400; n++) begin
      bit e, c, t;
      logic [LEN_W-1:0] l;
      logic [TAG_W-1:0] tg;
      e = ($urandom % 6) == 0;
      c = ($urandom % 8) == 0;
      t = $urandom % 2;
      tg = TAG_W'($urandom % 9);
      l = (n % 25 == 0) ? LEN_W'($urandom) : LEN_W'($urandom_range(0, 9600));
      send_frame(e, c, l, tg, t);
      if (n % 80 == 79) check_all("R2 R3 R4 R5 R6 random");
    end

    // R8 write with bit0 low: no effect
    wr_word(BASE, 32'hFFFF_FFFE);
    check_all("R8 bit0 low no clear");

    // R8 clear with frames in the write cycle and the next one
    @(negedge clk);
    reg_addr_i = BASE; reg_wdata_i = 32'h1; reg_wr_i = 1;
    drive_frame(0, 0, 1000, 0, 0);
    @(negedge clk);
    reg_wr_i = 0;
    drive_frame(0, 1, 0, 0, 0);
    @(negedge clk);
    eof_valid_i = 0;
    for (int i = 0; i < 4; i++) mdl[i] = 0;
    check_all("R8 clear wins");

    // R9 snapshot coherence
    send_frame(0, 0, 32'hFFFF_FFFF, 0, 0);
    send_frame(0, 0, 32'hFFFF_FFFF, 0, 0);
    rd_word(BASE + 10'd8, d);
    chk(d == 32'hFFFF_FFFE, "R9 low word", d, 32'hFFFF_FFFE);
    send_frame(0, 0, 32'hFFFF_FFFF, 0, 0);
    rd_word(BASE + 10'd9, d);
    chk(d == 32'h1, "R9 high from snapshot", d, 32'h1);
    check_cnt(3, "R9 fresh pair");

    // R10 wrap
    wr_word(BASE, 32'h1);
    for (int i = 0; i < 4; i++) mdl[i] = 0;
    for (int i = 0; i < 16; i++) send_frame(0, 0, 32'hFFFF_FFFF, 0, 0);
    check_cnt(3, "R10 near top");
    send_frame(0, 0, 20, 0, 0);
    chk(mdl[3] == 4, "R10 model wrap", mdl[3], 4);
    check_cnt(3, "R10 wrapped");
    check_cnt(0, "R10 frame count");

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule